// File: doc/BRIEF.md
# Thermal Refresh and Throttle Manager

This block sits beside a stacked-DRAM controller. It turns the stack's 3-bit temperature code and its over-temperature trip line into three things: refresh requests, a traffic stall, and gated AXI ready signals.

A down-counter paces the automatic refreshes. Its length comes from the temperature code, and hotter codes give shorter intervals. Software can also ask for a refresh through a small APB register. That request is merged with the automatic ones, and a single acknowledge serves both.

Traffic control is a three-state machine:

- **RUN** passes the ready signals through.
- **THROTTLE** is entered when throttling is enabled and the code is at or above a programmed level. It blocks the first N cycles of every M-cycle window.
- **TRIPPED** is entered from any state when the trip input is sampled high. It stalls everything and is left only through reset.

The transitions are:

- RUN→THROTTLE on the over-level condition.
- THROTTLE→RUN when that condition drops.
- RUN/THROTTLE→TRIPPED on trip.
- TRIPPED→TRIPPED always.

Top module: `thermal_guard`

## Requirements
- R1: After reset the state is RUN and refresh_req is 0. stall is 0, each usr_*ready equals its ctl_*ready, the throttle control register reads 0 and the ratio register reads the RATIO_RST parameter (default 8'h31).
- R2: With a constant temperature code c, the automatic interval is I = max(1, BASE_INTERVAL >> c). refresh_req rises I clock edges after reset or after the edge that takes an acknowledge.
- R3: If the code changes so that the remaining count exceeds the new interval, the remaining count is cut to the new interval at once.
- R4: An acknowledge is taken when refresh_ack and refresh_req are both high at a clock edge. It clears refresh_req at that edge and reloads the counter. An acknowledge while refresh_req is low has no effect, and refresh_req stays high until it is acknowledged.
- R5: An APB write to address 0x0 with bit 0 set makes a user request pending. Reading address 0x0 returns the pending flag in bit 0. A pending user request drives refresh_req, and a taken acknowledge clears it.
- R6: Address 0x4 holds the throttle control: bit 3 is enable and bits 2:0 are the level. From RUN the state moves to THROTTLE at the next edge when enable is 1 and temp_code is at or above the level. It returns to RUN when that condition is false.
- R7: Address 0x8 holds the ratio: bits 7:4 are M-1 and bits 3:0 are N. In THROTTLE a phase counter starts at 0 and wraps after M-1, and stall is 1 while phase < N. If N ≥ M, stall is 1 on every cycle; if N = 0, stall stays 0.
- R8: Each usr_*ready equals its ctl_*ready AND NOT stall, in the same cycle.
- R9: trip_in sampled high at a clock edge makes stall 1 from that edge on. stall stays 1 regardless of trip_in, temperature or register writes until reset.
- R10: In TRIPPED, refresh_req is 0 even with an automatic or user request pending.
- R11: An APB read of address 0xC, or any read with psel low, returns 0. An APB write to 0xC changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| temp_code | input | 3 | Temperature code from the stack, higher is hotter |
| trip_in | input | 1 | Catastrophic over-temperature trip |
| refresh_ack | input | 1 | Controller accepts the pending refresh |
| refresh_req | output | 1 | Refresh wanted (automatic or user) |
| ctl_awready | input | 1 | Write-address ready from controller |
| ctl_wready | input | 1 | Write-data ready from controller |
| ctl_arready | input | 1 | Read-address ready from controller |
| usr_awready | output | 1 | Gated write-address ready |
| usr_wready | output | 1 | Gated write-data ready |
| usr_arready | output | 1 | Gated read-address ready |
| stall | output | 1 | Traffic blocked (trip or throttle) |
| psel | input | 1 | APB select |
| penable | input | 1 | APB enable |
| pwrite | input | 1 | APB write |
| paddr | input | 4 | APB byte address |
| pwdata | input | 8 | APB write data |
| prdata | output | 8 | APB read data |

## Verification
A wrong interval lookup or a missed clamp shows as refresh_req rising on the wrong edge, visible in the very cycle it differs. A phase counter that drifts or fails to restart shows as stall in the wrong slot of the first throttle window. A trip latch that leaks shows as stall or refresh_req changing after trip_in falls, within one cycle. The reference model is compared on every clock, so any such divergence is flagged in the cycle it first appears.

// File: rtl/tg_pkg.sv
package tg_pkg;
    typedef enum logic [1:0] {
        ST_RUN      = 2'd0,
        ST_THROTTLE = 2'd1,
        ST_TRIPPED  = 2'd2
    } tg_state_e;

    localparam logic [1:0] SEL_REFRESH  = 2'd0;
    localparam logic [1:0] SEL_THROTTLE = 2'd1;
    localparam logic [1:0] SEL_RATIO    = 2'd2;

    // Hotter code -> shorter interval, never below one cycle.
    function automatic int unsigned refresh_interval(input int unsigned base,
                                                     input logic [2:0] code);
        int unsigned v;
        v = base >> code;
        return (v == 0) ? 1 : v;
    endfunction
endpackage

// File: rtl/tg_apb_regs.sv
module tg_apb_regs #(
    parameter int          AW        = 4,
    parameter int          DW        = 8,
    parameter logic [7:0]  RATIO_RST = 8'h31
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          psel,
    input  logic          penable,
    input  logic          pwrite,
    input  logic [AW-1:0] paddr,
    input  logic [DW-1:0] pwdata,
    output logic [DW-1:0] prdata,
    input  logic          refresh_taken,
    output logic          user_pend,
    output logic          thr_en,
    output logic [2:0]    thr_level,
    output logic [3:0]    ratio_n,
    output logic [3:0]    ratio_pm1
);
    import tg_pkg::*;

    logic       wr;
    logic [1:0] sel;
    logic [3:0] thr_reg;
    logic [7:0] ratio_reg;

    assign wr  = psel & penable & pwrite;
    assign sel = paddr[3:2];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            user_pend <= 1'b0;
            thr_reg   <= '0;
            ratio_reg <= RATIO_RST;
        end else begin
            if (wr && sel == SEL_REFRESH && pwdata[0])
                user_pend <= 1'b1;
            else if (refresh_taken)
                user_pend <= 1'b0;
            if (wr && sel == SEL_THROTTLE)
                thr_reg <= pwdata[3:0];
            if (wr && sel == SEL_RATIO)
                ratio_reg <= pwdata[7:0];
        end
    end

    always_comb begin
        prdata = '0;
        if (psel && !pwrite) begin
            unique case (sel)
                SEL_REFRESH:  prdata[0]   = user_pend;
                SEL_THROTTLE: prdata[3:0] = thr_reg;
                SEL_RATIO:    prdata[7:0] = ratio_reg;
                default:      prdata      = '0;
            endcase
        end
    end

    assign thr_en    = thr_reg[3];
    assign thr_level = thr_reg[2:0];
    assign ratio_n   = ratio_reg[3:0];
    assign ratio_pm1 = ratio_reg[7:4];

    p_user_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && sel == SEL_REFRESH && pwdata[0]) |=> user_pend);

    p_user_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (user_pend && !refresh_taken) |=> user_pend);
endmodule

// File: rtl/tg_refresh_timer.sv
module tg_refresh_timer #(
    parameter int BASE_INTERVAL = 256,
    parameter int CW            = $clog2(BASE_INTERVAL + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] temp_code,
    input  logic       refresh_taken,
    output logic       auto_pend
);
    import tg_pkg::*;

    logic [CW-1:0] cnt;
    logic [CW-1:0] iv;
    logic [CW-1:0] eff;

    assign iv  = CW'(refresh_interval(BASE_INTERVAL, temp_code));
    assign eff = (cnt < iv) ? cnt : iv;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt       <= CW'(BASE_INTERVAL);
            auto_pend <= 1'b0;
        end else if (refresh_taken) begin
            cnt       <= iv;
            auto_pend <= 1'b0;
        end else if (!auto_pend) begin
            if (eff <= CW'(1)) begin
                cnt       <= '0;
                auto_pend <= 1'b1;
            end else begin
                cnt <= eff - CW'(1);
            end
        end
    end

    p_ack_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_taken |=> !auto_pend);

    p_pend_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_pend && !refresh_taken) |=> auto_pend);
endmodule

// File: rtl/tg_throttle_phase.sv
module tg_throttle_phase #(
    parameter int PW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          active,
    input  logic [PW-1:0] period_m1,
    input  logic [PW-1:0] nblock,
    output logic          block
);
    logic [PW-1:0] phase;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            phase <= '0;
        else if (!active || phase >= period_m1)
            phase <= '0;
        else
            phase <= phase + PW'(1);
    end

    assign block = active && (phase < nblock);

    p_first_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(active) && nblock != '0) |-> block);

    p_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (active && phase >= period_m1) |=> (phase == '0));
endmodule

// File: rtl/thermal_guard.sv
module thermal_guard #(
    parameter int         BASE_INTERVAL = 256,
    parameter logic [7:0] RATIO_RST     = 8'h31
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] temp_code,
    input  logic       trip_in,
    input  logic       refresh_ack,
    output logic       refresh_req,
    input  logic       ctl_awready,
    input  logic       ctl_wready,
    input  logic       ctl_arready,
    output logic       usr_awready,
    output logic       usr_wready,
    output logic       usr_arready,
    output logic       stall,
    input  logic       psel,
    input  logic       penable,
    input  logic       pwrite,
    input  logic [3:0] paddr,
    input  logic [7:0] pwdata,
    output logic [7:0] prdata
);
    import tg_pkg::*;

    localparam int CW = $clog2(BASE_INTERVAL + 1);

    tg_state_e  state, state_nx;
    logic       user_pend, auto_pend, taken;
    logic       thr_en, over_level, thr_block;
    logic [2:0] thr_level;
    logic [3:0] ratio_n, ratio_pm1;

    tg_apb_regs #(.AW(4), .DW(8), .RATIO_RST(RATIO_RST)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .refresh_taken(taken), .user_pend(user_pend),
        .thr_en(thr_en), .thr_level(thr_level),
        .ratio_n(ratio_n), .ratio_pm1(ratio_pm1)
    );

    tg_refresh_timer #(.BASE_INTERVAL(BASE_INTERVAL), .CW(CW)) u_timer (
        .clk(clk), .rst_n(rst_n), .temp_code(temp_code),
        .refresh_taken(taken), .auto_pend(auto_pend)
    );

    tg_throttle_phase #(.PW(4)) u_phase (
        .clk(clk), .rst_n(rst_n), .active(state == ST_THROTTLE),
        .period_m1(ratio_pm1), .nblock(ratio_n), .block(thr_block)
    );

    assign over_level = thr_en && (temp_code >= thr_level);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= state_nx;
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_RUN: begin
                if (trip_in)         state_nx = ST_TRIPPED;
                else if (over_level) state_nx = ST_THROTTLE;
            end
            ST_THROTTLE: begin
                if (trip_in)          state_nx = ST_TRIPPED;
                else if (!over_level) state_nx = ST_RUN;
            end
            ST_TRIPPED: state_nx = ST_TRIPPED;
            default:    state_nx = ST_TRIPPED;
        endcase
    end

    // Outputs
    always_comb begin
        stall       = 1'b0;
        refresh_req = 1'b0;
        unique case (state)
            ST_RUN: begin
                refresh_req = auto_pend | user_pend;
            end
            ST_THROTTLE: begin
                refresh_req = auto_pend | user_pend;
                stall       = thr_block;
            end
            ST_TRIPPED: begin
                stall = 1'b1;
            end
            default: stall = 1'b1;
        endcase
        usr_awready = ctl_awready & ~stall;
        usr_wready  = ctl_wready  & ~stall;
        usr_arready = ctl_arready & ~stall;
    end

    assign taken = refresh_ack & refresh_req;

    p_trip_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TRIPPED) |=> (state == ST_TRIPPED) && stall);

    p_trip_enter_r9: assert property (@(posedge clk) disable iff (!rst_n)
        trip_in |=> stall);

    p_trip_no_refresh_r10: assert property (@(posedge clk) disable iff (!rst_n)
        trip_in |=> !refresh_req);

    p_throttle_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && over_level && !trip_in) |=> (state == ST_THROTTLE));

    p_throttle_exit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_THROTTLE && !over_level && !trip_in) |=> (state == ST_RUN));
endmodule

// File: tb/tb_thermal_guard.sv
module tb_thermal_guard;
    localparam int         BASE = 256;
    localparam logic [7:0] RRST = 8'h31;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] temp_code = 3'd0;
    logic       trip_in = 1'b0, refresh_ack = 1'b0;
    logic       refresh_req, stall;
    logic       ctl_awready = 1'b1, ctl_wready = 1'b1, ctl_arready = 1'b1;
    logic       usr_awready, usr_wready, usr_arready;
    logic       psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [3:0] paddr = 4'd0;
    logic [7:0] pwdata = 8'd0, prdata;

    int    n_checks = 0, n_errors = 0, cyc = 0;
    string cur_req = "R1";
    bit    rdy_toggle = 1'b0;

    // Reference model state
    int       m_state, m_phase, m_cnt;
    bit       m_auto, m_user;
    bit [3:0] m_ctrl;
    bit [7:0] m_ratio;

    always #4 clk = ~clk;

    thermal_guard #(.BASE_INTERVAL(BASE), .RATIO_RST(RRST)) dut (
        .clk(clk), .rst_n(rst_n), .temp_code(temp_code), .trip_in(trip_in),
        .refresh_ack(refresh_ack), .refresh_req(refresh_req),
        .ctl_awready(ctl_awready), .ctl_wready(ctl_wready), .ctl_arready(ctl_arready),
        .usr_awready(usr_awready), .usr_wready(usr_wready), .usr_arready(usr_arready),
        .stall(stall), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata)
    );

    function automatic int ivl(input int code);
        int v;
        v = BASE / (1 << code);
        return (v < 1) ? 1 : v;
    endfunction

    function automatic bit exp_req();
        return (m_auto || m_user) && (m_state != 2);
    endfunction

    function automatic bit exp_stall();
        int n;
        n = m_ratio[3:0];
        return (m_state == 2) || (m_state == 1 && m_phase < n);
    endfunction

    function automatic logic [7:0] exp_prdata();
        if (!psel || pwrite) return 8'd0;
        case (paddr[3:2])
            2'd0:    return {7'd0, m_user};
            2'd1:    return {4'd0, m_ctrl};
            2'd2:    return m_ratio;
            default: return 8'd0;
        endcase
    endfunction

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", tag, what, act, exp, cyc);
        end
    endtask

    // Behavioural reference model, advanced on every edge
    always @(posedge clk or negedge rst_n) begin : model
        int  iv, eff, pm1, nst;
        bit  taken, wr, over;
        if (!rst_n) begin
            m_state = 0; m_phase = 0; m_cnt = BASE;
            m_auto = 0; m_user = 0; m_ctrl = 0; m_ratio = RRST;
        end else begin
            taken = refresh_ack && exp_req();
            wr    = psel && penable && pwrite;
            iv    = ivl(temp_code);
            // refresh counter
            if (taken) begin
                m_auto = 0; m_cnt = iv;
            end else if (!m_auto) begin
                eff = (m_cnt < iv) ? m_cnt : iv;
                if (eff <= 1) begin m_auto = 1; m_cnt = 0; end
                else m_cnt = eff - 1;
            end
            // user pending
            if (wr && paddr[3:2] == 0 && pwdata[0]) m_user = 1;
            else if (taken) m_user = 0;
            // throttle phase (uses pre-edge ratio)
            pm1 = m_ratio[7:4];
            if (m_state != 1 || m_phase >= pm1) m_phase = 0;
            else m_phase = m_phase + 1;
            // state
            over = m_ctrl[3] && (temp_code >= m_ctrl[2:0]);
            if (trip_in || m_state == 2) nst = 2;
            else nst = over ? 1 : 0;
            m_state = nst;
            if (wr && paddr[3:2] == 1) m_ctrl = pwdata[3:0];
            if (wr && paddr[3:2] == 2) m_ratio = pwdata;
        end
    end

    // Ready stimulus pattern
    always @(negedge clk) begin
        cyc++;
        if (rdy_toggle) begin
            ctl_awready <= cyc[0] ^ cyc[3];
            ctl_wready  <= cyc[1];
            ctl_arready <= ~cyc[2] | cyc[0];
        end
    end

    // Per-cycle comparison against the model
    always begin
        @(negedge clk);
        #2;
        if (rst_n) begin
            check(cur_req, "refresh_req", refresh_req, exp_req());
            check(cur_req, "stall", stall, exp_stall());
            check("R8", "usr_awready", usr_awready, ctl_awready & ~exp_stall());
            check("R8", "usr_wready", usr_wready, ctl_wready & ~exp_stall());
            check("R8", "usr_arready", usr_arready, ctl_arready & ~exp_stall());
            check(cur_req, "prdata", prdata, exp_prdata());
        end
    end

    // Watchdog
    initial begin
        #(8 * 100000);
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic apb_wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
        @(negedge clk);
        penable = 1;
        @(negedge clk);
        psel = 0; penable = 0; pwrite = 0;
    endtask

    task automatic apb_rd(input string tag, input logic [3:0] a, input int exp);
        @(negedge clk);
        psel = 1; pwrite = 0; paddr = a; penable = 0;
        #1;
        check(tag, "apb read", prdata, exp);
        @(negedge clk);
        penable = 1;
        @(negedge clk);
        psel = 0; penable = 0;
    endtask

    // Waits for refresh_req, returns negedges spent waiting, then acknowledges
    task automatic wait_ack(output int waited);
        waited = 0;
        @(negedge clk);
        while (!refresh_req && waited < 2000) begin
            @(negedge clk);
            waited++;
        end
        refresh_ack = 1;
        @(negedge clk);
        refresh_ack = 0;
    endtask

    initial begin
        int w;
        // R1: reset state
        cycles(3);
        rst_n = 1;
        #1;
        check("R1", "refresh_req", refresh_req, 0);
        check("R1", "stall", stall, 0);
        check("R1", "usr_wready", usr_wready, 1);
        apb_rd("R1", 4'h4, 0);
        apb_rd("R1", 4'h8, RRST);
        rdy_toggle = 1;

        // R2: code 0 interval from reset, then code 3 interval after ack
        cur_req = "R2";
        wait_ack(w);
        temp_code = 3'd3;
        wait_ack(w);
        check("R2", "interval code 3", w, ivl(3) - 1);

        // R4: ack while idle ignored, request holds until ack
        cur_req = "R4";
        temp_code = 3'd6;
        refresh_ack = 1;
        cycles(1);
        refresh_ack = 0;
        cycles(ivl(6) + 10);
        check("R4", "req held", refresh_req, 1);
        wait_ack(w);

        // R3: long count, then hotter code clamps
        cur_req = "R3";
        temp_code = 3'd0;
        wait_ack(w);
        cycles(20);
        temp_code = 3'd5;
        wait_ack(w);
        check("R3", "clamped wait", w <= ivl(5), 1);

        // R5: user request
        cur_req = "R5";
        temp_code = 3'd0;
        apb_wr(4'h0, 8'h01);
        apb_rd("R5", 4'h0, 1);
        check("R5", "user req", refresh_req, 1);
        wait_ack(w);
        apb_rd("R5", 4'h0, 0);

        // R6/R7: throttle entry, ratio, exit
        cur_req = "R6";
        apb_wr(4'h8, 8'h31);
        apb_wr(4'h4, 8'h0C);
        temp_code = 3'd3;
        cycles(8);
        check("R6", "below level", stall, 0);
        cur_req = "R7";
        temp_code = 3'd4;
        cycles(1);
        #2;
        check("R7", "first window slot", stall, 1);
        cycles(30);
        apb_wr(4'h8, 8'h25);
        cycles(12);
        apb_wr(4'h8, 8'h50);
        cycles(12);
        apb_wr(4'h8, 8'h42);
        cycles(20);
        cur_req = "R6";
        temp_code = 3'd1;
        cycles(3);
        check("R6", "exit stall", stall, 0);

        // R11: unmapped address
        cur_req = "R11";
        apb_wr(4'hC, 8'hFF);
        apb_rd("R11", 4'hC, 0);
        apb_rd("R11", 4'h4, 8'h0C);
        apb_rd("R11", 4'h8, 8'h42);

        // R9/R10: trip is sticky, refresh suppressed
        cur_req = "R9";
        temp_code = 3'd7;
        cycles(2);
        trip_in = 1;
        cycles(1);
        trip_in = 0;
        temp_code = 3'd0;
        apb_wr(4'h4, 8'h00);
        cycles(20);
        check("R9", "sticky stall", stall, 1);
        cur_req = "R10";
        apb_wr(4'h0, 8'h01);
        cycles(300);
        check("R10", "req in trip", refresh_req, 0);
        check("R9", "ready blocked", usr_arready, 0);

        // Reset clears trip
        cur_req = "R1";
        rst_n = 0;
        cycles(2);
        rst_n = 1;
        #1;
        check("R1", "stall after reset", stall, 0);
        check("R1", "req after reset", refresh_req, 0);
        cycles(5);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule